// File: doc/BRIEF.md
# Oscillator Fingerprint and Random-Byte Sequencer

This block is the control engine that sits between a bank of free-running oscillators and the logic that reads their results. On a start pulse it clears the external edge counters, opens a measurement window of a programmable number of clock cycles, waits one settling cycle, and then turns the eight counter values into an 8-bit result.

It has two functions. In fingerprint mode a single window is run and neighbouring oscillators are compared pairwise, which gives a 4-bit device signature. In random mode the window is repeated eight times, and each round contributes one bit: the parity of all eight counter LSBs. The result register is loaded, or shifted, only inside the block. It holds its value while `done` is high, until the next accepted start.

Control and status pins are plain levels. The counts come in as a flat vector that the block samples in its settling cycle. The result is held stable for as long as the host needs, so the block needs no valid/ready handshake.

Top module: `osc_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `cnt_clr_o` and `win_en_o` are 0, `result_o` is 0, and the window length register holds 64.
- R2: The rising edge that samples `start_i` while the block is idle or done is followed by exactly one cycle with `cnt_clr_o`=1. Then come exactly W cycles with `win_en_o`=1, where W is the window value and 0 means 256, and then one settling cycle with neither.
- R3: With `mode_i` = 2'b00, 2'b01 or 2'b11 at the start edge, the result bit i (i = 0..3) is 1 exactly when count[2i] > count[2i+1] (strict), and bits 7:4 are 0. Count k sits in `counts_i[8k+7:8k]`.
- R4: In fingerprint mode, `done_o` first reads 1 after the (W+2)-th rising edge following the start edge.
- R5: With `mode_i` = 2'b10 at the start edge, eight rounds are run back to back, each as in R2. Each round yields the XOR of bit 0 of all eight counts.
- R6: In random mode, each new bit enters `result_o[7]` while the older bits move down one place, so the first round's bit ends in bit 0. `done_o` first reads 1 after 8·(W+2) edges.
- R7: `busy_o` is 1 from the edge after an accepted start until the edge that raises `done_o`. `busy_o` and `done_o` are never 1 together.
- R8: A start pulse that arrives while `busy_o` is 1 is ignored and does not change the timing or the result of the run in progress.
- R9: `cfg_we_i` writes `cfg_window_i` into the window register. The value is captured at the next accepted start, and a write during a run does not change that run.
- R10: While `done_o` is 1 and no start arrives, `result_o` and `done_o` hold their values. An accepted start clears `result_o` to 0 and lowers `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on each edge |
| mode_i | input | 2 | 2'b10 random, otherwise fingerprint; captured at start |
| cfg_we_i | input | 1 | Window register write strobe |
| cfg_window_i | input | 8 | Window length to write (0 = 256 cycles) |
| counts_i | input | 64 | Eight 8-bit edge counts, count k at bits 8k+7:8k |
| win_en_o | output | 1 | Counting window open |
| cnt_clr_o | output | 1 | Clear the external counters |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Result ready |
| result_o | output | 8 | Fingerprint bits or random byte |

## Verification
The fingerprint function is tried with three kinds of period sets. In the first, every even oscillator is faster than its partner, which must give 0x0F. In the second, every even oscillator is slower, which must give 0x00. In the third, the pairs are tied or mixed, which separates a strict comparison from a non-strict one and checks each bit position on its own. The fingerprint is also tried with the mode values 01 and 11, and with a window of 0 to check the 256-cycle wrap. Random mode uses jittered oscillator edges, so each round's parity varies. This exposes a wrong shift direction, a missing round or a wrong parity source through the every-cycle comparison with the bench model. Start pulses during a run and window writes during a run show whether the timing of that run moves.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_MEAS   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_t;

  localparam logic [1:0] MODE_RANDOM = 2'b10;
endpackage

// File: rtl/osc_seq_timer.sv
module osc_seq_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [WIN_W-1:0] limit_i,
  output logic             last_o
);
  logic [WIN_W-1:0] elapsed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      elapsed_q <= '0;
    else if (clr_i)  elapsed_q <= '0;
    else if (run_i)  elapsed_q <= elapsed_q + 1'b1;
  end

  // a limit of zero wraps to all ones, giving 2**WIN_W cycles
  assign last_o = (elapsed_q == limit_i - 1'b1);
endmodule

// File: rtl/osc_seq_fold.sv
module osc_seq_fold #(
  parameter int NUM_OSC = 8,
  parameter int CNT_W   = 8,
  parameter int RES_W   = 8
) (
  input  logic [NUM_OSC*CNT_W-1:0] counts_i,
  output logic [RES_W-1:0]         print_o,
  output logic                     parity_o
);
  localparam int NPAIR = NUM_OSC / 2;

  logic [NPAIR-1:0] beats;

  genvar g;
  generate
    for (g = 0; g < NPAIR; g++) begin : g_pair
      assign beats[g] = counts_i[(2*g)*CNT_W +: CNT_W] > counts_i[(2*g+1)*CNT_W +: CNT_W];
    end
  endgenerate

  assign print_o = {{(RES_W-NPAIR){1'b0}}, beats};

  always_comb begin
    parity_o = 1'b0;
    for (int k = 0; k < NUM_OSC; k++) parity_o = parity_o ^ counts_i[k*CNT_W];
  end
endmodule

// File: rtl/osc_seq_acc.sv
module osc_seq_acc #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [RES_W-1:0] print_i,
  input  logic             bit_i,
  output logic [RES_W-1:0] res_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_o <= '0;
    else if (clr_i)   res_o <= '0;
    else if (load_i)  res_o <= print_i;
    else if (shift_i) res_o <= {bit_i, res_o[RES_W-1:1]};
  end
endmodule

// File: rtl/osc_seq.sv
module osc_seq
  import osc_seq_pkg::*;
#(
  parameter int NUM_OSC     = 8,
  parameter int CNT_W       = 8,
  parameter int WIN_W       = 8,
  parameter int RES_W       = 8,
  parameter int WIN_DEFAULT = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [1:0]               mode_i,
  input  logic                     cfg_we_i,
  input  logic [WIN_W-1:0]         cfg_window_i,
  input  logic [NUM_OSC*CNT_W-1:0] counts_i,
  output logic                     win_en_o,
  output logic                     cnt_clr_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [RES_W-1:0]         result_o
);
  localparam int ROUNDS = RES_W;
  localparam int RND_W  = $clog2(ROUNDS);
  localparam logic [RND_W-1:0] LAST_ROUND = RND_W'(ROUNDS - 1);

  seq_state_t       state_q, state_d;
  logic [WIN_W-1:0] win_cfg_q, win_snap_q;
  logic             rnd_q;
  logic [RND_W-1:0] round_q;
  logic             accept, last, settle, parity;
  logic [RES_W-1:0] print;

  assign accept = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign settle = (state_q == ST_SETTLE);

  osc_seq_timer #(.WIN_W(WIN_W)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (state_q == ST_CLEAR),
    .run_i   (state_q == ST_MEAS),
    .limit_i (win_snap_q),
    .last_o  (last)
  );

  osc_seq_fold #(.NUM_OSC(NUM_OSC), .CNT_W(CNT_W), .RES_W(RES_W)) fold_i (
    .counts_i (counts_i),
    .print_o  (print),
    .parity_o (parity)
  );

  osc_seq_acc #(.RES_W(RES_W)) acc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (accept),
    .load_i  (settle && !rnd_q),
    .shift_i (settle && rnd_q),
    .print_i (print),
    .bit_i   (parity),
    .res_o   (result_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = ST_CLEAR;
      ST_CLEAR:         state_d = ST_MEAS;
      ST_MEAS:          if (last) state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (!rnd_q || round_q == LAST_ROUND) state_d = ST_DONE;
        else                                 state_d = ST_CLEAR;
      end
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      win_cfg_q  <= WIN_W'(WIN_DEFAULT);
      win_snap_q <= WIN_W'(WIN_DEFAULT);
      rnd_q      <= 1'b0;
      round_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cfg_we_i) win_cfg_q <= cfg_window_i;
      if (accept) begin
        win_snap_q <= win_cfg_q;
        rnd_q      <= (mode_i == MODE_RANDOM);
        round_q    <= '0;
      end else if (settle && rnd_q) begin
        round_q <= round_q + 1'b1;
      end
    end
  end

  assign cnt_clr_o = (state_q == ST_CLEAR);
  assign win_en_o  = (state_q == ST_MEAS);
  assign busy_o    = (state_q == ST_CLEAR) || (state_q == ST_MEAS) || settle;
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/osc_seq_chk.sv
module osc_seq_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             win_en_o,
  input logic             cnt_clr_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o
);
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  assert_busy_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  assert_clear_then_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_o |=> (win_en_o && !cnt_clr_o));

  assert_ctl_inside_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr_o || win_en_o) |-> busy_o);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en_o && start_i) |=> !cnt_clr_o);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(result_o)));
endmodule

bind osc_seq osc_seq_chk #(.RES_W(RES_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .win_en_o  (win_en_o),
  .cnt_clr_o (cnt_clr_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/osc_seq_tb.sv
module osc_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_window_i = 8'd0;
  logic [63:0] counts_i = '0;
  logic        win_en_o, cnt_clr_o, busy_o, done_o;
  logic [7:0]  result_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .cfg_we_i(cfg_we_i), .cfg_window_i(cfg_window_i), .counts_i(counts_i),
    .win_en_o(win_en_o), .cnt_clr_o(cnt_clr_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o)
  );

  int n_vec = 0, n_bad = 0;
  int cyc = 0;
  int per[8];
  int cnt[8];
  bit jitter = 0;

  // behavioural model
  bit       m_act = 0, m_rnd = 0, m_done = 0;
  int       m_t = 0, m_w = 64, m_round = 0, m_win = 64;
  bit [7:0] m_res = 0;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit [7:0] ref_print();
    bit [7:0] r = 0;
    for (int i = 0; i < 4; i++) r[i] = (cnt[2*i] > cnt[2*i+1]);
    return r;
  endfunction

  function automatic bit ref_parity();
    bit p = 0;
    for (int i = 0; i < 8; i++) p ^= cnt[i][0];
    return p;
  endfunction

  // advance the model across the coming rising edge
  task automatic model_edge();
    int w_old = m_win;
    if (cfg_we_i) m_win = cfg_window_i;
    if (!m_act && start_i) begin
      m_act = 1; m_done = 0; m_t = 0; m_round = 0; m_res = 0;
      m_rnd = (mode_i == 2'b10);
      m_w = (w_old == 0) ? 256 : w_old;
    end else if (m_act) begin
      m_t++;
      if (m_t == m_w + 2) begin
        if (m_rnd) begin
          m_res = {ref_parity(), m_res[7:1]};
          m_round++;
          if (m_round == 8) begin m_act = 0; m_done = 1; end
          else m_t = 0;
        end else begin
          m_res = ref_print(); m_act = 0; m_done = 1;
        end
      end
    end
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk("R7 busy", busy_o, m_act);
    chk("R4 done", done_o, m_done);
    chk("R2 cnt_clr", cnt_clr_o, m_act && m_t == 0);
    chk("R2 win_en", win_en_o, m_act && m_t >= 1 && m_t <= m_w);
    chk(m_rnd ? "R5/R6 result" : "R3 result", result_o, m_res);
    // external counter bank, driven by the block's own controls
    for (int i = 0; i < 8; i++) begin
      if (cnt_clr_o) cnt[i] = 0;
      else if (win_en_o) begin
        if (jitter ? ($urandom_range(per[i]-1) == 0) : (cyc % per[i] == 0))
          cnt[i] = (cnt[i] + 1) % 256;
      end
      counts_i[i*8 +: 8] = cnt[i][7:0];
    end
  endtask

  task automatic set_per(int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7);
    per[0]=a0; per[1]=a1; per[2]=a2; per[3]=a3; per[4]=a4; per[5]=a5; per[6]=a6; per[7]=a7;
  endtask

  task automatic write_win(int w);
    cfg_we_i = 1; cfg_window_i = 8'(w); tick(); cfg_we_i = 0;
  endtask

  // start a run; optionally pulse start again or write the window mid-run
  task automatic run(bit [1:0] md, int exp_edges, string tag, int poke_at, bit poke_cfg);
    int lat;
    mode_i = md; start_i = 1; tick(); start_i = 0; mode_i = 2'b00;
    lat = 1;
    while (!done_o && lat < 5000) begin
      if (lat == poke_at) begin
        if (poke_cfg) begin cfg_we_i = 1; cfg_window_i = 8'd20; end
        else start_i = 1;
      end
      tick();
      start_i = 0; cfg_we_i = 0;
      lat++;
    end
    chk(tag, lat - 1, exp_edges);
  endtask

  initial begin
    bit [7:0] held;
    set_per(4, 8, 4, 8, 6, 12, 4, 12);
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0); chk("R1 result", result_o, 0);
    rst_n = 1;
    tick(); tick();

    // R1 default window of 64, R3/R4 even oscillators faster
    run(2'b00, 66, "R1 R4 latency", 0, 0);
    chk("R3 fast pairs", result_o, 8'h0F);

    // R10 hold while done
    held = result_o;
    repeat (5) tick();
    chk("R10 hold", result_o, held);
    chk("R10 done held", done_o, 1);

    // R3 slower even oscillators, mode 01
    set_per(12, 4, 12, 4, 8, 4, 12, 6);
    run(2'b01, 66, "R4 latency", 0, 0);
    chk("R3 slow pairs", result_o, 8'h00);

    // R3 ties and mixes, mode 11, short window (R9)
    set_per(4, 4, 8, 4, 5, 5, 4, 16);
    write_win(5);
    run(2'b11, 7, "R9 new window", 0, 0);

    // R8 start during run ignored
    set_per(4, 8, 12, 4, 6, 6, 4, 12);
    run(2'b00, 7, "R8 start ignored", 3, 0);

    // R9 write during run does not affect it, next run uses it
    run(2'b00, 7, "R9 write mid-run", 2, 1);
    run(2'b00, 22, "R9 next run", 0, 0);

    // R5/R6 random byte with jitter
    jitter = 1;
    set_per(2, 3, 2, 3, 2, 3, 2, 3);
    write_win(10);
    run(2'b10, 96, "R6 random latency", 0, 0);
    run(2'b10, 96, "R6 random latency 2", 40, 0);
    jitter = 0;

    // R2 window 0 means 256 cycles
    set_per(4, 8, 4, 8, 6, 12, 4, 12);
    write_win(0);
    run(2'b00, 258, "R2 wrap window", 0, 0);
    chk("R3 wrap result", result_o, 8'h0F);
    repeat (3) tick();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule